// File: doc/BRIEF.md
# Flash Toggle Status Generator

This block is the status half of a parallel NOR-style flash read path. While the embedded sequencer runs a program or an erase, every read returns a status byte instead of array contents. Bit 6 of that byte inverts on each read to show that some operation is running. Bit 2 inverts only on reads that land in a sector marked for erase, and it keeps doing so while the erase is suspended. A host can read twice and compare: a bit that changed means work is still in progress.

Each bit lives in its own flip-flop. The flip-flop advances on the read strobe, which marks the end of a read cycle, so the value seen during a read is the one stored before that read. The block also covers commands that hit protected sectors. An erase whose selected sectors are all protected, or a program aimed at a protected sector, produces a short stretch of toggling with no real operation behind it. That stretch is timed in clock cycles derived from a clock-frequency parameter, and reads then go back to array data.

Top module: `flash_toggle_status`

## Requirements
- R1: While `prog_busy` is high, or `erase_busy` is high with `erase_susp` low, each read strobe inverts `dq6` one cycle later, and `status_sel` is 1.
- R2: With no operation running and no protection window open, reads leave `dq6` unchanged and `status_sel` is 0 (array data), except for reads covered by R7.
- R3: While the erase is suspended and no program is running, read strobes leave `dq6` unchanged.
- R4: A program running during erase suspend (`prog_busy` and `erase_susp` both high) makes `dq6` invert on each read strobe.
- R5: A `cmd_erase_go` pulse whose `erase_sel` is non-zero and entirely covered by `prot_mask` opens a window of exactly 100*CLK_MHZ cycles. During the window `status_sel` is 1 and reads invert `dq6`.
- R6: A `cmd_prog_go` pulse whose `prog_sector` has its `prot_mask` bit set opens a window of exactly 1*CLK_MHZ cycles. A pulse aimed at an unprotected sector opens no window.
- R7: While `erase_busy` or `erase_susp` is high, a read at a sector whose `erase_sel` bit is 1 returns the stored bit-2 value on `dq2`, inverts that value one cycle later, and drives `status_sel` to 1.
- R8: A read at a sector whose `erase_sel` bit is 0, or any read with no erase active or suspended, returns `dq2` = 1 and does not advance the stored bit-2 value.
- R9: Without a read strobe, `dq6` holds its value.
- R10: After reset `dq6` is 0, `dq2` is 1, the stored bit-2 value is 0, and `status_sel` is 0.
- R11: An erase command that selects at least one unprotected sector opens no protection window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | One-cycle pulse at the end of a read cycle |
| rd_sector | input | SW | Sector index of the read address |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Embedded erase running, including the sector time-out |
| erase_susp | input | 1 | Erase suspended |
| erase_sel | input | SECTORS | Sectors selected for erase |
| prot_mask | input | SECTORS | Protected sectors |
| cmd_erase_go | input | 1 | Erase command accepted (last write edge) |
| cmd_prog_go | input | 1 | Program command accepted (last write edge) |
| prog_sector | input | SW | Sector index of the program target |
| dq6 | output | 1 | Operation toggle bit |
| dq2 | output | 1 | Erase-sector toggle bit |
| status_sel | output | 1 | 1: status byte on the bus, 0: array data |

## Verification
`dq6`, `dq2` and `status_sel` are combinational from the stored state and the sector inputs, so the value a read returns is due in the same cycle as its strobe. Bench reads are checked one time unit after the falling edge on which the strobe is raised. The inversion caused by a strobe shows up after the next rising edge, and the bench model applies it only after it queues the expected item for that read. A window opened by a command pulse is loaded on the rising edge that samples the pulse. The bench therefore checks `status_sel` high on the last cycle of the window and low on the cycle after it, counting falling edges from the edge where the pulse is dropped.

// File: rtl/fsts_pkg.sv
package fsts_pkg;
  // Window length in clock cycles for a given duration in microseconds
  function automatic int unsigned usec_to_ticks(int unsigned clk_mhz, int unsigned usec);
    return clk_mhz * usec;
  endfunction

  // Index width for a sector count
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fsts_sector_lookup.sv
module fsts_sector_lookup #(
  parameter int unsigned SECTORS = 8,
  localparam int unsigned SW = fsts_pkg::idx_width(SECTORS)
) (
  input  logic [SECTORS-1:0] erase_sel,
  input  logic [SECTORS-1:0] prot_mask,
  input  logic [SW-1:0]      rd_sector,
  input  logic [SW-1:0]      prog_sector,
  output logic               rd_in_sel,
  output logic               prog_prot,
  output logic               erase_all_prot
);
  assign rd_in_sel      = erase_sel[rd_sector];
  assign prog_prot      = prot_mask[prog_sector];
  assign erase_all_prot = (|erase_sel) && !(|(erase_sel & ~prot_mask));
endmodule

// File: rtl/fsts_guard_timer.sv
module fsts_guard_timer #(
  parameter int unsigned LONG_TICKS  = 100,
  parameter int unsigned SHORT_TICKS = 1,
  localparam int unsigned CW = $clog2(LONG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_long,
  input  logic start_short,
  output logic active
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start_long)      cnt_q <= CW'(LONG_TICKS);
    else if (start_short)     cnt_q <= CW'(SHORT_TICKS);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/fsts_toggle_cell.sv
module fsts_toggle_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= 1'b0;
    else if (advance) q <= ~q;
  end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
  parameter int unsigned SECTORS = 8,
  parameter int unsigned CLK_MHZ = 250,
  localparam int unsigned SW = fsts_pkg::idx_width(SECTORS),
  localparam int unsigned LONG_TICKS  = fsts_pkg::usec_to_ticks(CLK_MHZ, 100),
  localparam int unsigned SHORT_TICKS = fsts_pkg::usec_to_ticks(CLK_MHZ, 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_strobe,
  input  logic [SW-1:0]      rd_sector,
  input  logic               prog_busy,
  input  logic               erase_busy,
  input  logic               erase_susp,
  input  logic [SECTORS-1:0] erase_sel,
  input  logic [SECTORS-1:0] prot_mask,
  input  logic               cmd_erase_go,
  input  logic               cmd_prog_go,
  input  logic [SW-1:0]      prog_sector,
  output logic               dq6,
  output logic               dq2,
  output logic               status_sel
);
  logic rd_in_sel, prog_prot, erase_all_prot;
  logic win_active;
  logic run6;       // operation-level toggle condition
  logic dq2_hit;    // read lands in an erase-selected sector with erase pending
  logic dq6_state, dq2_state;

  fsts_sector_lookup #(.SECTORS(SECTORS)) u_lookup (
    .erase_sel      (erase_sel),
    .prot_mask      (prot_mask),
    .rd_sector      (rd_sector),
    .prog_sector    (prog_sector),
    .rd_in_sel      (rd_in_sel),
    .prog_prot      (prog_prot),
    .erase_all_prot (erase_all_prot)
  );

  fsts_guard_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_long  (cmd_erase_go && erase_all_prot),
    .start_short (cmd_prog_go && prog_prot),
    .active      (win_active)
  );

  assign run6    = prog_busy || (erase_busy && !erase_susp) || win_active;
  assign dq2_hit = (erase_busy || erase_susp) && rd_in_sel;

  fsts_toggle_cell u_dq6 (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (rd_strobe && run6),
    .q       (dq6_state)
  );

  fsts_toggle_cell u_dq2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (rd_strobe && dq2_hit),
    .q       (dq2_state)
  );

  assign dq6        = dq6_state;
  assign dq2        = dq2_hit ? dq2_state : 1'b1;
  assign status_sel = run6 || dq2_hit;
endmodule

// File: rtl/fsts_checker.sv
module fsts_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic dq6,
  input logic status_sel,
  input logic run6,
  input logic dq2_hit,
  input logic dq2_state,
  input logic win_active
);
  // R1
  dq6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && run6 |=> dq6 != $past(dq6));
  // R3
  dq6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !run6 |=> $stable(dq6));
  // R9
  dq6_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(dq6));
  // R7
  dq2_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && dq2_hit |=> dq2_state != $past(dq2_state));
  // R8
  dq2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !dq2_hit |=> $stable(dq2_state));
  // R5
  win_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> status_sel && run6);
endmodule

bind flash_toggle_status fsts_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .dq6        (dq6),
  .status_sel (status_sel),
  .run6       (run6),
  .dq2_hit    (dq2_hit),
  .dq2_state  (dq2_state),
  .win_active (win_active)
);

// File: tb/sim_flash_toggle_status.sv
`timescale 1ns/1ps
module sim_flash_toggle_status;
  localparam int unsigned N   = 8;
  localparam int unsigned MHZ = 4;
  localparam int unsigned SW  = 3;
  localparam int unsigned LONG_W  = 100 * MHZ;
  localparam int unsigned SHORT_W = MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0;
  logic [SW-1:0] rd_sector = '0;
  logic prog_busy = 1'b0, erase_busy = 1'b0, erase_susp = 1'b0;
  logic [N-1:0] erase_sel = '0, prot_mask = '0;
  logic cmd_erase_go = 1'b0, cmd_prog_go = 1'b0;
  logic [SW-1:0] prog_sector = '0;
  logic dq6, dq2, status_sel;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  flash_toggle_status #(.SECTORS(N), .CLK_MHZ(MHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .erase_susp(erase_susp),
    .erase_sel(erase_sel), .prot_mask(prot_mask),
    .cmd_erase_go(cmd_erase_go), .cmd_prog_go(cmd_prog_go),
    .prog_sector(prog_sector),
    .dq6(dq6), .dq2(dq2), .status_sel(status_sel)
  );

  typedef struct {
    logic [2:0] exp;   // {dq6, dq2, status_sel}
    string      req;
  } item_t;
  item_t sb[$];

  // Bench model of the stored bits
  logic m6 = 1'b0, m2 = 1'b0, win_m = 1'b0;

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Driver: one read, expected item queued from the requirements
  task automatic rd(input int s, input string req);
    logic run, hit;
    item_t it;
    @(negedge clk);
    rd_sector = SW'(s);
    rd_strobe = 1'b1;
    run = prog_busy || (erase_busy && !erase_susp) || win_m;
    hit = (erase_busy || erase_susp) && erase_sel[s];
    it.exp = {m6, hit ? m2 : 1'b1, run || hit};
    it.req = req;
    sb.push_back(it);
    if (run) m6 = ~m6;
    if (hit) m2 = ~m2;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    #1;
    if (rd_strobe) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.req, {dq6, dq2, status_sel}, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10", {dq6, dq2, status_sel}, 3'b010);

    // R2 idle reads return array data
    rd(0, "R2"); rd(4, "R2");

    // R1 program busy toggles dq6
    prog_busy = 1'b1;
    rd(3, "R1"); rd(3, "R1"); rd(6, "R1");
    // R9 no strobe, no change
    repeat (5) @(negedge clk);
    #1; check("R9", {dq6, status_sel}, {m6, 1'b1});
    rd(1, "R1");
    prog_busy = 1'b0;
    rd(2, "R2"); rd(2, "R2");

    // R7 / R8 erase with sectors 1 and 2 selected
    erase_sel = 8'b0000_0110;
    erase_busy = 1'b1;
    rd(1, "R7"); rd(2, "R7"); rd(5, "R8"); rd(5, "R8"); rd(1, "R7");

    // R3 suspend freezes dq6; dq2 still toggles in selected sectors
    erase_susp = 1'b1;
    rd(0, "R3"); rd(2, "R7"); rd(2, "R7"); rd(7, "R3");

    // R4 program during suspend
    prog_busy = 1'b1;
    rd(0, "R4"); rd(0, "R4"); rd(1, "R4");
    prog_busy = 1'b0;
    rd(0, "R3");
    erase_susp = 1'b0; erase_busy = 1'b0;
    // R8 no erase pending: dq2 constant
    rd(1, "R8");

    // R5 all-protected erase, exact window length
    prot_mask = 8'b0000_0110;
    @(negedge clk); cmd_erase_go = 1'b1;
    @(negedge clk); cmd_erase_go = 1'b0;
    repeat (LONG_W - 1) @(negedge clk);
    #1; check("R5 last cycle", {2'b00, status_sel}, 3'b001);
    @(negedge clk);
    #1; check("R5 after window", {2'b00, status_sel}, 3'b000);

    // R5 reads toggle dq6 inside the window
    @(negedge clk); cmd_erase_go = 1'b1;
    @(negedge clk); cmd_erase_go = 1'b0;
    win_m = 1'b1;
    rd(4, "R5"); rd(4, "R5"); rd(0, "R5");
    repeat (LONG_W) @(negedge clk);
    win_m = 1'b0;
    rd(4, "R5");

    // R6 protected program window
    prog_sector = 3'd2;
    @(negedge clk); cmd_prog_go = 1'b1;
    @(negedge clk); cmd_prog_go = 1'b0;
    repeat (SHORT_W - 1) @(negedge clk);
    #1; check("R6 last cycle", {2'b00, status_sel}, 3'b001);
    @(negedge clk);
    #1; check("R6 after window", {2'b00, status_sel}, 3'b000);
    // R6 unprotected target opens nothing
    prog_sector = 3'd3;
    @(negedge clk); cmd_prog_go = 1'b1;
    @(negedge clk); cmd_prog_go = 1'b0;
    #1; check("R6 unprotected", {2'b00, status_sel}, 3'b000);

    // R11 partly protected erase opens no window
    erase_sel = 8'b0000_0111;
    @(negedge clk); cmd_erase_go = 1'b1;
    @(negedge clk); cmd_erase_go = 1'b0;
    #1; check("R11", {2'b00, status_sel}, 3'b000);
    rd(6, "R11");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    finish_run();
  end
endmodule